// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Register

This block is one 32-bit lock register that several bus masters share. A master that wants the lock writes its own nonzero 12-bit identifier to the register with a full-word store. It then reads the register back. If the read returns exactly its identifier, it owns the lock. Otherwise another master holds it, and the requester tries again later.

A write only has effect when the register is empty, or when the written value is zero. Any other write is dropped without notice. A plain store followed by a load therefore behaves as an atomic test-and-set. The owner frees the lock by writing zero.

Two register-access ports reach the lock: one for the local processor and one for an external host-bus aperture. Each port decodes the lock address on its own. When both ports write in the same cycle, the local write is applied first. The external write is then judged against the result, exactly as if the two writes had come one after the other.

Top module: `sem_assist`

## Requirements
- R1: Reset (synchronous, active-high `rst`) clears the stored identifier to zero. Reads after reset return 0x00000000 on both ports.
- R2: A write to the lock address while the stored value is zero stores write-data bits 11..0. Bits 31..12 of the write data are discarded.
- R3: A write whose bits 11..0 are nonzero, made while the stored value is nonzero, leaves the stored value unchanged.
- R4: A write whose bits 11..0 are all zero clears a nonzero stored value, whichever master issues it. Bits 31..12 do not count in this zero test, so 0xFFFFF000 also clears the lock.
- R5: A read at the lock address returns the stored identifier in bits 11..0, with bits 31..12 always zero.
- R6: A read returns the value held at the end of the previous cycle. A write in the same cycle on either port is not visible until the next cycle.
- R7: The lock address is 0x100500 on the 24-bit address inputs. A write to any other address leaves the lock unchanged. Read data is 0 whenever the port's read strobe is low or its address differs.
- R8: When both ports write to the lock in one cycle, the local write is applied first. The external write is then judged against that result. Two nonzero claims on an empty lock leave the local identifier. A local release together with an external claim leaves the external identifier. A local claim on an empty lock together with an external zero write leaves zero.
- R9: Both ports read the same stored value in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_addr | input | 24 | Local port byte address |
| loc_wr | input | 1 | Local port write strobe |
| loc_wdata | input | 32 | Local port write data |
| loc_rd | input | 1 | Local port read strobe |
| loc_rdata | output | 32 | Local port read data |
| ext_addr | input | 24 | External port byte address |
| ext_wr | input | 1 | External port write strobe |
| ext_wdata | input | 32 | External port write data |
| ext_rd | input | 1 | External port read strobe |
| ext_rdata | output | 32 | External port read data |

## Verification
The hardest situation to reach is two writes landing in one cycle, where the order of evaluation decides the outcome. The stimulus drives both ports in the same cycle in three set-ups: two claims on an empty lock, a local release paired with an external claim on a held lock, and a local claim paired with an external zero write. Each set-up gives a different final owner, so any other order of evaluation shows up in the read that follows. Releases by a master that does not own the lock, zero writes with upper bits set, and writes to a neighbouring address are also driven, to show which writes the lock takes and which it drops.

// File: rtl/sem_pkg.sv
package sem_pkg;

    parameter int DATA_W = 32;
    parameter int ID_W   = 12;
    parameter int ADDR_W = 24;
    parameter int N_PORTS = 2;
    parameter logic [ADDR_W-1:0] SEM_ADDR = 24'h10_0500;

    localparam int PAD_W = DATA_W - ID_W;

    typedef logic [ID_W-1:0] sem_id_t;

    // Decoded view of one port's access in one cycle.
    typedef struct packed {
        logic    wr_hit;
        logic    rd_hit;
        sem_id_t id;
    } sem_op_t;

    // Conditional update rule for a single write.
    function automatic sem_id_t sem_next(input sem_id_t cur, input sem_id_t wval);
        sem_id_t res;
        if (cur == '0) begin
            res = wval;
        end else if (wval == '0) begin
            res = '0;
        end else begin
            res = cur;
        end
        return res;
    endfunction

    function automatic logic [DATA_W-1:0] sem_extend(input sem_id_t v);
        return {{PAD_W{1'b0}}, v};
    endfunction

endpackage

// File: rtl/sem_decode.sv
module sem_decode
    import sem_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter logic [AW-1:0] MATCH = SEM_ADDR
) (
    input  logic          wr,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  sem_id_t       wid,
    output sem_op_t       op
);

    logic hit;

    always_comb begin
        hit       = (addr == MATCH);
        op.wr_hit = wr && hit;
        op.rd_hit = rd && hit;
        op.id     = wid;
    end

endmodule

// File: rtl/sem_chain.sv
module sem_chain
    import sem_pkg::*;
#(
    parameter int NP = N_PORTS
) (
    input  sem_id_t             cur,
    input  logic [NP-1:0]       wr_hit,
    input  logic [NP-1:0][ID_W-1:0] wr_id,
    output sem_id_t             nxt
);

    // Writes are applied in port-index order; each stage sees the
    // result of the stages before it.
    sem_id_t stage [NP+1];

    assign stage[0] = cur;

    for (genvar i = 0; i < NP; i++) begin : g_stage
        assign stage[i+1] = wr_hit[i] ? sem_next(stage[i], wr_id[i]) : stage[i];
    end

    assign nxt = stage[NP];

endmodule

// File: rtl/sem_store.sv
module sem_store
    import sem_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  sem_id_t d,
    output sem_id_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/sem_assist.sv
module sem_assist
    import sem_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] loc_addr,
    input  logic              loc_wr,
    input  logic [DATA_W-1:0] loc_wdata,
    input  logic              loc_rd,
    output logic [DATA_W-1:0] loc_rdata,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              ext_wr,
    input  logic [DATA_W-1:0] ext_wdata,
    input  logic              ext_rd,
    output logic [DATA_W-1:0] ext_rdata
);

    localparam int P_LOC = 0;
    localparam int P_EXT = 1;

    // Port index order is the write priority order.
    logic [N_PORTS-1:0]              p_wr;
    logic [N_PORTS-1:0]              p_rd;
    logic [N_PORTS-1:0][ADDR_W-1:0]  p_addr;
    logic [N_PORTS-1:0][ID_W-1:0]    p_wid;
    logic [N_PORTS-1:0][DATA_W-1:0]  p_rdata;
    sem_op_t                         ops [N_PORTS];
    logic [N_PORTS-1:0]              wr_hit;
    logic [N_PORTS-1:0][ID_W-1:0]    wr_id;

    sem_id_t sem_q;
    sem_id_t sem_d;

    always_comb begin
        p_wr[P_LOC]   = loc_wr;
        p_rd[P_LOC]   = loc_rd;
        p_addr[P_LOC] = loc_addr;
        p_wid[P_LOC]  = loc_wdata[ID_W-1:0];
        p_wr[P_EXT]   = ext_wr;
        p_rd[P_EXT]   = ext_rd;
        p_addr[P_EXT] = ext_addr;
        p_wid[P_EXT]  = ext_wdata[ID_W-1:0];
    end

    for (genvar i = 0; i < N_PORTS; i++) begin : g_port
        sem_decode #(.AW(ADDR_W), .MATCH(SEM_ADDR)) u_dec (
            .wr   (p_wr[i]),
            .rd   (p_rd[i]),
            .addr (p_addr[i]),
            .wid  (p_wid[i]),
            .op   (ops[i])
        );
        assign wr_hit[i]  = ops[i].wr_hit;
        assign wr_id[i]   = ops[i].id;
        assign p_rdata[i] = ops[i].rd_hit ? sem_extend(sem_q) : '0;
    end

    sem_chain #(.NP(N_PORTS)) u_chain (
        .cur    (sem_q),
        .wr_hit (wr_hit),
        .wr_id  (wr_id),
        .nxt    (sem_d)
    );

    sem_store u_store (
        .clk (clk),
        .rst (rst),
        .d   (sem_d),
        .q   (sem_q)
    );

    assign loc_rdata = p_rdata[P_LOC];
    assign ext_rdata = p_rdata[P_EXT];

endmodule

// File: rtl/sem_assist_chk.sv
module sem_assist_chk
    import sem_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] loc_addr,
    input logic              loc_wr,
    input logic [DATA_W-1:0] loc_wdata,
    input logic              loc_rd,
    input logic [DATA_W-1:0] loc_rdata,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              ext_wr,
    input logic [DATA_W-1:0] ext_wdata,
    input logic              ext_rd,
    input logic [DATA_W-1:0] ext_rdata,
    input sem_id_t           sem_q
);

    logic lw, ew;
    assign lw = loc_wr && (loc_addr == SEM_ADDR);
    assign ew = ext_wr && (ext_addr == SEM_ADDR);

    p_reset_clear_r1: assert property (@(posedge clk) rst |=> sem_q == '0);

    p_claim_r2: assert property (@(posedge clk) disable iff (rst)
        (sem_q == '0 && lw && loc_wdata[ID_W-1:0] != '0 && !ew)
        |=> sem_q == $past(loc_wdata[ID_W-1:0]));

    p_reject_r3: assert property (@(posedge clk) disable iff (rst)
        (sem_q != '0 && !(lw && loc_wdata[ID_W-1:0] == '0)
                     && !(ew && ext_wdata[ID_W-1:0] == '0))
        |=> $stable(sem_q));

    p_release_r4: assert property (@(posedge clk) disable iff (rst)
        (sem_q != '0 && ew && ext_wdata[ID_W-1:0] == '0 && !lw)
        |=> sem_q == '0);

    p_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
        loc_rdata[DATA_W-1:ID_W] == '0 && ext_rdata[DATA_W-1:ID_W] == '0);

    p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
        !(ext_rd && ext_addr == SEM_ADDR) |-> ext_rdata == '0);

    p_local_first_r8: assert property (@(posedge clk) disable iff (rst)
        (sem_q == '0 && lw && ew && loc_wdata[ID_W-1:0] != '0
                     && ext_wdata[ID_W-1:0] != '0)
        |=> sem_q == $past(loc_wdata[ID_W-1:0]));

    p_same_view_r9: assert property (@(posedge clk) disable iff (rst)
        (loc_rd && ext_rd && loc_addr == SEM_ADDR && ext_addr == SEM_ADDR)
        |-> loc_rdata == ext_rdata);

endmodule

bind sem_assist sem_assist_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .loc_addr  (loc_addr),
    .loc_wr    (loc_wr),
    .loc_wdata (loc_wdata),
    .loc_rd    (loc_rd),
    .loc_rdata (loc_rdata),
    .ext_addr  (ext_addr),
    .ext_wr    (ext_wr),
    .ext_wdata (ext_wdata),
    .ext_rd    (ext_rd),
    .ext_rdata (ext_rdata),
    .sem_q     (sem_q)
);

// File: tb/sem_assist_bench.sv
`timescale 1ns/1ps
module sem_assist_bench;

    localparam logic [23:0] A_SEM   = 24'h10_0500;
    localparam logic [23:0] A_OTHER = 24'h10_0504;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] loc_addr = A_SEM, ext_addr = A_SEM;
    logic        loc_wr = 0, loc_rd = 0, ext_wr = 0, ext_rd = 0;
    logic [31:0] loc_wdata = 0, ext_wdata = 0;
    logic [31:0] loc_rdata, ext_rdata;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    typedef struct {
        int          cyc;
        bit          is_ext;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb [$];

    sem_assist u_sem_assist (
        .clk(clk), .rst(rst),
        .loc_addr(loc_addr), .loc_wr(loc_wr), .loc_wdata(loc_wdata),
        .loc_rd(loc_rd), .loc_rdata(loc_rdata),
        .ext_addr(ext_addr), .ext_wr(ext_wr), .ext_wdata(ext_wdata),
        .ext_rd(ext_rd), .ext_rdata(ext_rdata)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every item due in this cycle, away from the edge.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc == cyc) begin
            item_t it;
            logic [31:0] act;
            it  = sb.pop_front();
            act = it.is_ext ? ext_rdata : loc_rdata;
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s %s port: got %h expected %h",
                         it.tag, it.is_ext ? "ext" : "loc", act, it.exp);
            end
        end
    end

    // Driver: one cycle of stimulus on both ports plus expected read data.
    task automatic step(
        input bit lw, input logic [31:0] lwd, input bit lr, input logic [23:0] la,
        input bit ew, input logic [31:0] ewd, input bit er, input logic [23:0] ea,
        input bit lchk, input logic [31:0] lexp,
        input bit echk, input logic [31:0] eexp,
        input string tag);
        loc_wr = lw; loc_wdata = lwd; loc_rd = lr; loc_addr = la;
        ext_wr = ew; ext_wdata = ewd; ext_rd = er; ext_addr = ea;
        if (lchk) sb.push_back('{cyc, 1'b0, lexp, tag});
        if (echk) sb.push_back('{cyc, 1'b1, eexp, tag});
        @(posedge clk); #1;
    endtask

    task automatic rd_both(input logic [31:0] e, input string tag);
        step(0, 0, 1, A_SEM, 0, 0, 1, A_SEM, 1, e, 1, e, tag);
    endtask

    task automatic lwrite(input logic [31:0] v);
        step(1, v, 0, A_SEM, 0, 0, 0, A_SEM, 0, 0, 0, 0, "");
    endtask

    task automatic ewrite(input logic [31:0] v);
        step(0, 0, 0, A_SEM, 1, v, 0, A_SEM, 0, 0, 0, 0, "");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;

        rd_both(32'h0, "R1 reset value");

        // Claim with upper garbage; read in the same cycle still sees 0.
        step(1, 32'hABCD_E123, 1, A_SEM, 0, 0, 0, A_SEM, 1, 32'h0, 0, 0, "R6 read during write");
        rd_both(32'h0000_0123, "R2 R5 R9 claim by empty lock");

        // Second claimant rejected.
        ewrite(32'h0000_0456);
        rd_both(32'h0000_0123, "R3 second claimant rejected");
        lwrite(32'h0000_0FFF);
        rd_both(32'h0000_0123, "R3 owner overwrite rejected");

        // Non-owner release with nonzero upper bits.
        ewrite(32'hFFFF_F000);
        rd_both(32'h0, "R4 release by non-owner, upper bits ignored");

        // External claim, local zero write to another address.
        step(1, 32'h0, 0, A_OTHER, 1, 32'h0000_07FF, 0, A_SEM, 0, 0, 0, 0, "");
        step(0, 0, 1, A_OTHER, 0, 0, 1, A_SEM, 1, 32'h0, 1, 32'h0000_07FF, "R7 other address read zero");
        step(0, 0, 0, A_SEM, 0, 0, 1, A_OTHER, 1, 32'h0, 1, 32'h0, "R7 idle and mismatched read zero");
        rd_both(32'h0000_07FF, "R7 write elsewhere ignored");

        // Release by zero from owner.
        ewrite(32'h0);
        rd_both(32'h0, "R4 release by owner");

        // Simultaneous claims: local first wins.
        step(1, 32'h0000_0111, 0, A_SEM, 1, 32'h0000_0222, 0, A_SEM, 0, 0, 0, 0, "");
        rd_both(32'h0000_0111, "R8 simultaneous claims local wins");

        // Local release plus external claim in one cycle.
        step(1, 32'h0, 0, A_SEM, 1, 32'h0000_0333, 0, A_SEM, 0, 0, 0, 0, "");
        rd_both(32'h0000_0333, "R8 local release then external claim");

        // Local claim on empty plus external zero write.
        ewrite(32'h0);
        step(1, 32'h0000_00AA, 0, A_SEM, 1, 32'h0, 0, A_SEM, 0, 0, 0, 0, "");
        rd_both(32'h0, "R8 local claim then external release");

        // Several identifiers in turn.
        for (int k = 1; k < 6; k++) begin
            logic [31:0] id;
            id = 32'(k * 12'h2D1);
            lwrite(id);
            ewrite(32'h0000_0ABC);
            rd_both({20'h0, id[11:0]}, "R2 R3 claim sequence");
            lwrite(32'h0);
        end

        // Reset while held.
        lwrite(32'h0000_0555);
        rd_both(32'h0000_0555, "R2 held before reset");
        rst = 1; @(posedge clk); #1; rst = 0;
        rd_both(32'h0, "R1 reset clears held lock");

        @(posedge clk); #1;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule